// File: doc/BRIEF.md
# Stereo Serial Audio Word Receiver with Silence Flag

This block takes a stereo serial audio stream made of a bit clock, a channel-select word clock and a single data line. It turns that stream into parallel 16-bit samples for a downstream interpolation datapath. The block runs on a fast system clock. It samples the three serial inputs through a synchronizer chain and treats each rising edge of the synchronized bit clock as one data bit. The word clock level names the channel: high means left and low means right. A change of that level starts a new word, and the first bit after the change is the most significant bit.

When a word has all its bits, the block gives a one-cycle valid strobe. The strobe comes with the sample and a channel tag, so downstream logic can pair left and right samples. The block also tracks how long both channels have been silent. It raises a flag once a programmable number of word-clock periods (8192 by default) have passed with all-zero samples on both channels. The flag stays up for as long as the silence lasts, and any nonzero sample drops it at once.

Top module: `serial_audio_rx`

## Requirements
- R1: The serial data line is sampled on each rising edge of the bit clock, after the bit clock, word clock and data have passed through the same synchronizer chain of SYNC_STAGES flops in the system clock domain.
- R2: A word begins at the first bit-clock rising edge where the word clock level differs from its level at the previous rising edge. The bit captured at that edge is the word's MSB. The channel tag `smp_left` is 1 when the word clock was high (left) and 0 when it was low (right).
- R3: Only the first WORD_W (16) bits after a word-clock change are kept. Further bits in a longer slot are ignored and produce no extra strobe.
- R4: Each completed word produces a `smp_valid` pulse exactly one system-clock cycle long. `smp_data` and `smp_left` hold their values until the next completed word.
- R5: Samples are two's complement, most significant bit first. The word is presented unchanged, with its sign bit in `smp_data[15]`.
- R6: While `rst_n` is low, all outputs are 0. After reset, no word is produced until the first word-clock level change seen at a bit-clock rising edge.
- R7: A word-clock period counts as silent when a zero left word is followed by a zero right word. `zero_flag` goes high when ZERO_RUN (default 8192) consecutive silent periods have been counted. The count saturates there, so the flag stays high while silence continues.
- R8: Any nonzero word on either channel clears the silent-period count and drops `zero_flag` in the cycle after that word's strobe.
- R9: A period whose left word is nonzero is not counted, even if its right word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock |
| word_clk | input | 1 | Channel select: high = left, low = right |
| ser_data | input | 1 | Serial sample data, MSB first |
| smp_valid | output | 1 | One-cycle strobe for a completed word |
| smp_left | output | 1 | Channel tag of the presented word (1 = left) |
| smp_data | output | 16 | Completed two's-complement sample |
| zero_flag | output | 1 | High after a long run of silent periods |

## Verification
The embedded assertions check the following on every cycle:
- the valid strobe and the synchronized bit-clock edge are single-cycle;
- the bit counter never passes the word width;
- the silence counter never passes its terminal count;
- the flag persists while no nonzero word arrives;
- a nonzero word always clears the count and the flag in the next cycle.

Only the bench scenarios can show the following:
- correct word values, channel pairing and MSB-first ordering;
- truncation of long slots;
- the quiet arming phase after reset;
- the exact period count at which the flag rises;
- that a half-silent period is not counted.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      CH_RIGHT = 1'b0,
      CH_LEFT  = 1'b1
   } chan_e;
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_in,
   input  logic lr_in,
   input  logic sd_in,
   output logic bck_rise,
   output logic lr_s,
   output logic sd_s
);
   localparam int W = 3;

   if (STAGES < 1) begin : g_bad_stages
      $error("sar_edge_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];
   logic         bck_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= {bck_in, lr_in, sd_in};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_prev <= 1'b0;
      else        bck_prev <= stg[STAGES-1][2];
   end

   assign bck_rise = stg[STAGES-1][2] & ~bck_prev;
   assign lr_s     = stg[STAGES-1][1];
   assign sd_s     = stg[STAGES-1][0];

   // R1: a detected bit-clock edge lasts one system cycle
   a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      bck_rise |=> !bck_rise);
endmodule

// File: rtl/sar_deser.sv
module sar_deser
   import sar_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              lr,
   input  logic              sd,
   output logic              wd_valid,
   output chan_e             wd_chan,
   output logic [WORD_W-1:0] wd_data
);
   localparam int CW = $clog2(WORD_W + 1);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);

   if (WORD_W < 2) begin : g_bad_width
      $error("sar_deser: WORD_W must be at least 2");
   end

   logic              armed;
   logic              prev_lr;
   logic [CW-1:0]     bit_cnt;
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         prev_lr  <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         wd_valid <= 1'b0;
         wd_chan  <= CH_RIGHT;
         wd_data  <= '0;
      end else begin
         wd_valid <= 1'b0;
         if (rise) begin
            if (!armed) begin
               armed   <= 1'b1;
               prev_lr <= lr;
            end else if (lr != prev_lr) begin
               prev_lr <= lr;
               shreg   <= {{(WORD_W-1){1'b0}}, sd};
               bit_cnt <= CW'(1);
            end else if (bit_cnt != '0 && bit_cnt < FULL) begin
               shreg   <= {shreg[WORD_W-2:0], sd};
               bit_cnt <= bit_cnt + CW'(1);
               if (bit_cnt == LAST) begin
                  wd_valid <= 1'b1;
                  wd_data  <= {shreg[WORD_W-2:0], sd};
                  wd_chan  <= prev_lr ? CH_LEFT : CH_RIGHT;
               end
            end
         end
      end
   end

   // R3: the bit counter never runs past the word width
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);
   // R4: a word strobe is a single-cycle pulse
   a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wd_valid |=> !wd_valid);
endmodule

// File: rtl/sar_zero_det.sv
module sar_zero_det
   import sar_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ZERO_RUN = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_valid,
   input  chan_e             wd_chan,
   input  logic [WORD_W-1:0] wd_data,
   output logic              zero_flag
);
   localparam int ZCW = $clog2(ZERO_RUN + 1);
   localparam logic [ZCW-1:0] ZMAX = ZCW'(ZERO_RUN);

   if (ZERO_RUN < 1) begin : g_bad_run
      $error("sar_zero_det: ZERO_RUN must be at least 1");
   end

   logic [ZCW-1:0] cnt;
   logic           left_zero;
   logic           nz;

   assign nz = wd_valid && (wd_data != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         left_zero <= 1'b0;
      end else if (wd_valid) begin
         if (wd_data != '0) begin
            cnt       <= '0;
            left_zero <= 1'b0;
         end else if (wd_chan == CH_LEFT) begin
            left_zero <= 1'b1;
         end else begin
            left_zero <= 1'b0;
            if (left_zero && cnt != ZMAX) cnt <= cnt + ZCW'(1);
         end
      end
   end

   assign zero_flag = (cnt == ZMAX);

   // R7: the silence count saturates at its terminal value
   a_r7_sat: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ZMAX);
   // R7: the flag persists while no nonzero word arrives
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      zero_flag && !nz |=> zero_flag);
   // R8: a nonzero word drops the flag and the count
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      nz |=> !zero_flag && cnt == '0);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ZERO_RUN    = 8192,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk,
   input  logic              word_clk,
   input  logic              ser_data,
   output logic              smp_valid,
   output logic              smp_left,
   output logic [WORD_W-1:0] smp_data,
   output logic              zero_flag
);
   logic  bck_rise, lr_s, sd_s;
   chan_e chan;

   sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bck_in   (bit_clk),
      .lr_in    (word_clk),
      .sd_in    (ser_data),
      .bck_rise (bck_rise),
      .lr_s     (lr_s),
      .sd_s     (sd_s)
   );

   sar_deser #(.WORD_W(WORD_W)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (bck_rise),
      .lr       (lr_s),
      .sd       (sd_s),
      .wd_valid (smp_valid),
      .wd_chan  (chan),
      .wd_data  (smp_data)
   );

   sar_zero_det #(.WORD_W(WORD_W), .ZERO_RUN(ZERO_RUN)) u_zero (
      .clk       (clk),
      .rst_n     (rst_n),
      .wd_valid  (smp_valid),
      .wd_chan   (chan),
      .wd_data   (smp_data),
      .zero_flag (zero_flag)
   );

   assign smp_left = (chan == CH_LEFT);
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb_top;
   localparam int ZR = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_clk = 1'b0;
   logic        word_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        smp_valid, smp_left, zero_flag;
   logic [15:0] smp_data;

   int          n_chk = 0;
   int          n_fail = 0;
   int          cap_n = 0;
   logic [15:0] cap_d [64];
   logic        cap_l [64];

   always #5 clk = ~clk;

   serial_audio_rx #(.WORD_W(16), .ZERO_RUN(ZR), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_clk(word_clk),
      .ser_data(ser_data), .smp_valid(smp_valid), .smp_left(smp_left),
      .smp_data(smp_data), .zero_flag(zero_flag)
   );

   always @(negedge clk) begin
      if (smp_valid) begin
         if (cap_n < 64) begin
            cap_d[cap_n] = smp_data;
            cap_l[cap_n] = smp_left;
         end
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send_slot(input logic lr, input logic [31:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         word_clk = lr;
         ser_data = bits[31-i];
         bit_clk  = 1'b0;
         repeat (2) @(negedge clk);
         bit_clk = 1'b1;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
      send_slot(1'b1, {l, 16'h0}, 16);
      send_slot(1'b0, {r, 16'h0}, 16);
   endtask

   task automatic settle();
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      word_clk = 1'b1;
      ser_data = 1'b1;
      for (int i = 0; i < 4; i++) begin
         bit_clk = ~bit_clk;
         repeat (3) @(negedge clk);
      end
      chk(smp_valid == 1'b0 && cap_n == 0, "R6 reset valid", {31'b0, smp_valid}, 0);
      chk(smp_data == 16'h0 && smp_left == 1'b0, "R6 reset data", {15'b0, smp_left, smp_data}, 0);
      chk(zero_flag == 1'b0, "R6 reset flag", {31'b0, zero_flag}, 0);
      bit_clk = 1'b0; word_clk = 1'b0; ser_data = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic t_arm();
      int base = cap_n;
      send_slot(1'b0, 32'hFFFF_0000, 16);
      settle();
      chk(cap_n == base, "R6 no word before first change", cap_n - base, 0);
   endtask

   task automatic t_basic();
      int base = cap_n;
      send_frame(16'h1234, 16'hA5C3);
      settle();
      chk(cap_n == base + 2, "R4 two words", cap_n - base, 2);
      chk(cap_l[base] == 1'b1 && cap_d[base] == 16'h1234, "R1 R2 left word",
          {15'b0, cap_l[base], cap_d[base]}, 32'h1_1234);
      chk(cap_l[base+1] == 1'b0 && cap_d[base+1] == 16'hA5C3, "R2 R5 right word",
          {15'b0, cap_l[base+1], cap_d[base+1]}, 32'h0_A5C3);
   endtask

   task automatic t_long();
      int base = cap_n;
      send_slot(1'b1, 32'hBEEF_7100, 24);
      send_slot(1'b0, 32'h8001_F000, 20);
      settle();
      chk(cap_n == base + 2, "R3 one strobe per long slot", cap_n - base, 2);
      chk(cap_d[base] == 16'hBEEF, "R3 left truncated", cap_d[base], 16'hBEEF);
      chk(cap_d[base+1] == 16'h8001, "R5 negative sample", cap_d[base+1], 16'h8001);
      chk(smp_valid == 1'b0 && smp_data == 16'h8001 && smp_left == 1'b0,
          "R4 held after strobe", {15'b0, smp_left, smp_data}, 32'h0_8001);
   endtask

   task automatic t_zero();
      for (int i = 0; i < ZR - 1; i++) send_frame(16'h0, 16'h0);
      settle();
      chk(zero_flag == 1'b0, "R7 flag low one period short", {31'b0, zero_flag}, 0);
      send_frame(16'h0, 16'h0);
      settle();
      chk(zero_flag == 1'b1, "R7 flag at terminal count", {31'b0, zero_flag}, 1);
      for (int i = 0; i < 3; i++) send_frame(16'h0, 16'h0);
      settle();
      chk(zero_flag == 1'b1, "R7 flag saturates", {31'b0, zero_flag}, 1);
      send_slot(1'b1, 32'h0040_0000, 16);
      settle();
      chk(zero_flag == 1'b0, "R8 left nonzero drops flag", {31'b0, zero_flag}, 0);
      send_slot(1'b0, 32'h0, 16);
      for (int i = 0; i < ZR - 1; i++) send_frame(16'h0, 16'h0);
      settle();
      chk(zero_flag == 1'b0, "R9 half-silent period not counted", {31'b0, zero_flag}, 0);
      send_frame(16'h0, 16'h0);
      settle();
      chk(zero_flag == 1'b1, "R7 flag after fresh run", {31'b0, zero_flag}, 1);
      send_frame(16'h0, 16'h0100);
      settle();
      chk(zero_flag == 1'b0, "R8 right nonzero drops flag", {31'b0, zero_flag}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_arm();
      t_basic();
      t_long();
      t_zero();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule